// File: doc/BRIEF.md
# Sync Presence Detection and Vertical Source Selection

This block watches three sync signals around a display front end: a combined horizontal/vertical sync input, a separate pure vertical sync input, and a vertical sync that the block derives itself from the combined input with a pulse-width integrator. For each source it holds a presence flag. A flag is set by the first pulse seen and stays set until a host clears it. The block measures the polarity of both external inputs and drives its own inverters, so both corrected outputs are always active-high.

A small register-side port replaces the serial bus slave. A write strobe carries three data bits: clear-detection, automatic mode and vertical select. A separate acknowledge pulse marks the end of the transfer. A requested clear takes effect only at that acknowledge. In host mode the written select bit chooses the vertical source. In automatic mode the block chooses the source from its own presence flags and keeps the current choice when both vertical sources are present.

Top module: `sync_select`

## Requirements
- R1: After reset all three presence flags, both polarity bits, the auto bit and the select bit are 0, and both sync outputs are 0 while the inputs are idle low.
- R2: A presence flag goes to 1 on the first rising edge of its polarity-corrected source and then stays 1 whatever the input does, until a clear.
- R3: A write with the clear bit set does not change the flags when the strobe arrives. All three flags drop together at the next acknowledge pulse. An acknowledge after a write whose clear bit is 0 clears nothing. After a clear, a new pulse sets the flag again.
- R4: A polarity bit is 1 (negative) when the high time of its input exceeds the low time over the last period, measured between rising edges, and 0 otherwise. hv_sync_o is the synchronized input XOR its polarity bit, so it is low while the input sits at its idle level.
- R5: With the auto bit at 0, a write loads the select bit from the written data (0 = pure vertical, 1 = extracted vertical), and the select bit does not change without a write.
- R6: A write loads the auto bit. A write that sets the auto bit ignores the written select value.
- R7: In automatic mode, while both vertical presence flags are 1, the select bit keeps its current value.
- R8: In automatic mode, when only one vertical flag is 1 the select bit moves to that source (pure gives 0, extracted gives 1). When neither flag is 1, the select bit holds.
- R9: v_sync_o is the polarity-corrected pure vertical input when the select bit is 0, and the extracted vertical signal when it is 1.
- R10: The extracted vertical signal rises once the integrator, which counts up while the corrected composite is high and down while it is low, reaches the upper threshold (48 by default). It falls only when the count gets down to the lower threshold (16), so short line pulses never produce it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hv_sync_i | input | 1 | Combined H/V sync, asynchronous |
| v_sync_i | input | 1 | Pure vertical sync, asynchronous |
| wr_en_i | input | 1 | Control register write strobe |
| wr_clr_i | input | 1 | Write data: request to clear the presence flags |
| wr_auto_i | input | 1 | Write data: automatic selection mode |
| wr_vsel_i | input | 1 | Write data: vertical source select (host mode) |
| ack_i | input | 1 | Transfer acknowledge pulse |
| hv_det_o | output | 1 | Combined sync presence flag |
| v_det_o | output | 1 | Pure vertical presence flag |
| vx_det_o | output | 1 | Extracted vertical presence flag |
| hv_pol_o | output | 1 | Combined sync polarity, 1 = negative |
| v_pol_o | output | 1 | Pure vertical polarity, 1 = negative |
| auto_o | output | 1 | Automatic mode bit |
| vsel_o | output | 1 | Vertical source select, 1 = extracted |
| hv_sync_o | output | 1 | Corrected combined sync, active-high |
| v_sync_o | output | 1 | Selected corrected vertical sync, active-high |

## Verification
The bench reads the flags between the write strobe and the acknowledge. A design that clears on the strobe loses them early. A design that clears on any acknowledge wipes them after a write that only changes the mode. Random pulse widths of both polarities test the high-versus-low comparison, and an inverted comparison would leave the corrected outputs idling high. The automatic-mode sequence reaches the state where both vertical sources are present from each side. A design that prefers a fixed source, or that returns to a default when the flags are cleared, ends up with the wrong select value. The long composite pulse is sampled after it ends, inside the hysteresis band, to catch an extractor with a single threshold.

// File: rtl/sync_sel_pkg.sv
package sync_sel_pkg;
  typedef struct packed {
    logic hv;
    logic v;
    logic vx;
  } det_flags_t;

  localparam logic VSEL_PURE = 1'b0;
  localparam logic VSEL_EXTR = 1'b1;
endpackage

// File: rtl/sync_pol_det.sv
module sync_pol_det #(
  parameter int CNT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic corr_o,
  output logic pol_o,
  output logic rise_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [1:0]       sync_q;
  logic             raw_d_q;
  logic             corr_d_q;
  logic             pol_q;
  logic [CNT_W-1:0] hi_q;
  logic [CNT_W-1:0] lo_q;
  logic             raw;
  logic             raw_rise;

  assign raw      = sync_q[1];
  assign raw_rise = raw & ~raw_d_q;
  assign corr_o   = raw ^ pol_q;
  assign pol_o    = pol_q;
  assign rise_o   = corr_o & ~corr_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      raw_d_q  <= 1'b0;
      corr_d_q <= 1'b0;
      pol_q    <= 1'b0;
      hi_q     <= '0;
      lo_q     <= '0;
    end else begin
      sync_q   <= {sync_q[0], sig_i};
      raw_d_q  <= raw;
      corr_d_q <= corr_o;
      if (raw_rise) begin
        // one full period ends here: longer high phase means negative pulses
        pol_q <= (hi_q > lo_q);
        hi_q  <= '0;
        lo_q  <= '0;
      end else if (raw) begin
        if (hi_q != CMAX) hi_q <= hi_q + 1'b1;
      end else begin
        if (lo_q != CMAX) lo_q <= lo_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sync_vextract.sv
module sync_vextract #(
  parameter int CNT_W = 7,
  parameter int HI_TH = 48,
  parameter int LO_TH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic out_o,
  output logic rise_o
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] HI_V = CNT_W'(HI_TH);
  localparam logic [CNT_W-1:0] LO_V = CNT_W'(LO_TH);

  logic [CNT_W-1:0] cnt_q;
  logic             out_q;
  logic             out_d_q;

  assign out_o  = out_q;
  assign rise_o = out_q & ~out_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      out_q   <= 1'b0;
      out_d_q <= 1'b0;
    end else begin
      out_d_q <= out_q;
      if (in_i && cnt_q != CMAX)       cnt_q <= cnt_q + 1'b1;
      else if (!in_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      if (cnt_q >= HI_V)      out_q <= 1'b1;
      else if (cnt_q <= LO_V) out_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_sel_ctrl.sv
module sync_sel_ctrl
  import sync_sel_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  det_flags_t rise_i,
  input  logic       wr_en_i,
  input  logic       wr_clr_i,
  input  logic       wr_auto_i,
  input  logic       wr_vsel_i,
  input  logic       ack_i,
  output det_flags_t flags_o,
  output logic       auto_o,
  output logic       vsel_o,
  output logic       clr_pend_o
);
  det_flags_t flags_q;
  logic       pend_q;
  logic       auto_q;
  logic       vsel_q;
  logic       clr;

  assign clr        = ack_i & pend_q;
  assign flags_o    = flags_q;
  assign auto_o     = auto_q;
  assign vsel_o     = vsel_q;
  assign clr_pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      pend_q  <= 1'b0;
      auto_q  <= 1'b0;
      vsel_q  <= VSEL_PURE;
    end else begin
      if (wr_en_i)    pend_q <= wr_clr_i;
      else if (ack_i) pend_q <= 1'b0;
      // a pulse in the clear cycle is kept
      flags_q <= (flags_q & {3{~clr}}) | rise_i;
      if (wr_en_i) auto_q <= wr_auto_i;
      if (wr_en_i && !wr_auto_i) begin
        vsel_q <= wr_vsel_i;
      end else if (auto_q) begin
        if (flags_q.v && !flags_q.vx)      vsel_q <= VSEL_PURE;
        else if (flags_q.vx && !flags_q.v) vsel_q <= VSEL_EXTR;
      end
    end
  end
endmodule

// File: rtl/sync_select.sv
module sync_select
  import sync_sel_pkg::*;
#(
  parameter int POL_CNT_W = 8,
  parameter int EX_CNT_W  = 7,
  parameter int EX_HI_TH  = 48,
  parameter int EX_LO_TH  = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hv_sync_i,
  input  logic v_sync_i,
  input  logic wr_en_i,
  input  logic wr_clr_i,
  input  logic wr_auto_i,
  input  logic wr_vsel_i,
  input  logic ack_i,
  output logic hv_det_o,
  output logic v_det_o,
  output logic vx_det_o,
  output logic hv_pol_o,
  output logic v_pol_o,
  output logic auto_o,
  output logic vsel_o,
  output logic hv_sync_o,
  output logic v_sync_o
);
  det_flags_t rise;
  det_flags_t flags;
  logic       hv_corr;
  logic       v_corr;
  logic       vx_act;
  logic       clr_pend;

  sync_pol_det #(.CNT_W(POL_CNT_W)) u_hv_pol (
    .clk_i, .rst_ni, .sig_i(hv_sync_i),
    .corr_o(hv_corr), .pol_o(hv_pol_o), .rise_o(rise.hv)
  );

  sync_pol_det #(.CNT_W(POL_CNT_W)) u_v_pol (
    .clk_i, .rst_ni, .sig_i(v_sync_i),
    .corr_o(v_corr), .pol_o(v_pol_o), .rise_o(rise.v)
  );

  sync_vextract #(.CNT_W(EX_CNT_W), .HI_TH(EX_HI_TH), .LO_TH(EX_LO_TH)) u_vx (
    .clk_i, .rst_ni, .in_i(hv_corr), .out_o(vx_act), .rise_o(rise.vx)
  );

  sync_sel_ctrl u_ctrl (
    .clk_i, .rst_ni, .rise_i(rise),
    .wr_en_i, .wr_clr_i, .wr_auto_i, .wr_vsel_i, .ack_i,
    .flags_o(flags), .auto_o, .vsel_o, .clr_pend_o(clr_pend)
  );

  assign hv_det_o  = flags.hv;
  assign v_det_o   = flags.v;
  assign vx_det_o  = flags.vx;
  assign hv_sync_o = hv_corr;
  assign v_sync_o  = (vsel_o == VSEL_EXTR) ? vx_act : v_corr;
endmodule

// File: rtl/sync_select_sva.sv
module sync_select_sva (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic ack_i,
  input logic clr_pend,
  input logic hv_det_o,
  input logic v_det_o,
  input logic vx_det_o,
  input logic auto_o,
  input logic vsel_o,
  input logic vx_act,
  input logic v_sync_o
);
  assert_hv_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_det_o && !ack_i |=> hv_det_o);
  assert_v_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_det_o && !ack_i |=> v_det_o);
  assert_vx_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vx_det_o && !ack_i |=> vx_det_o);
  assert_clear_needs_pend_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hv_det_o && !(ack_i && clr_pend) |=> hv_det_o);
  assert_host_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_o && !wr_en_i |=> $stable(vsel_o));
  assert_auto_keep_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_o && v_det_o && vx_det_o && !wr_en_i |=> $stable(vsel_o));
  assert_auto_pure_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_o && v_det_o && !vx_det_o && !wr_en_i |=> !vsel_o);
  assert_auto_extr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    auto_o && vx_det_o && !v_det_o && !wr_en_i |=> vsel_o);
  assert_vmux_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsel_o |-> (v_sync_o == vx_act));
endmodule

bind sync_select sync_select_sva u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .ack_i(ack_i),
  .clr_pend(clr_pend), .hv_det_o(hv_det_o), .v_det_o(v_det_o),
  .vx_det_o(vx_det_o), .auto_o(auto_o), .vsel_o(vsel_o),
  .vx_act(vx_act), .v_sync_o(v_sync_o)
);

// File: tb/sync_select_test.sv
`timescale 1ns/1ps
module sync_select_test;
  localparam int PER = 64;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hv_sync_i = 1'b0, v_sync_i = 1'b0;
  logic wr_en_i = 1'b0, wr_clr_i = 1'b0, wr_auto_i = 1'b0, wr_vsel_i = 1'b0, ack_i = 1'b0;
  logic hv_det_o, v_det_o, vx_det_o, hv_pol_o, v_pol_o, auto_o, vsel_o, hv_sync_o, v_sync_o;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  sync_select uut (
    .clk_i(clk), .rst_ni, .hv_sync_i, .v_sync_i, .wr_en_i, .wr_clr_i, .wr_auto_i,
    .wr_vsel_i, .ack_i, .hv_det_o, .v_det_o, .vx_det_o, .hv_pol_o, .v_pol_o,
    .auto_o, .vsel_o, .hv_sync_o, .v_sync_o
  );

  function automatic logic exp_pol(int high_t, int low_t);
    return high_t > low_t;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic clr, input logic au, input logic vs);
    @(negedge clk);
    wr_en_i = 1'b1; wr_clr_i = clr; wr_auto_i = au; wr_vsel_i = vs;
    @(negedge clk);
    wr_en_i = 1'b0; wr_clr_i = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); ack_i = 1'b1;
    @(negedge clk); ack_i = 1'b0;
  endtask

  // one period: active level for w cycles, idle level for the rest
  task automatic hv_pulses(input int n, input int w, input logic neg);
    for (int i = 0; i < n; i++) begin
      hv_sync_i = ~neg; cyc(w);
      hv_sync_i = neg;  cyc(PER - w);
    end
  endtask

  task automatic v_pulses(input int n, input int w, input logic neg);
    for (int i = 0; i < n; i++) begin
      v_sync_i = ~neg; cyc(w);
      v_sync_i = neg;  cyc(PER - w);
    end
  endtask

  task automatic long_pulse();
    hv_sync_i = 1'b1; cyc(60);
    hv_sync_i = 1'b0; cyc(80);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    rst_ni = 1'b1;
    cyc(5);
    // R1 reset state
    check("R1 flags", {hv_det_o, v_det_o, vx_det_o}, 0);
    check("R1 pol", {hv_pol_o, v_pol_o}, 0);
    check("R1 auto/vsel", {auto_o, vsel_o}, 0);
    check("R1 outputs", {hv_sync_o, v_sync_o}, 0);

    // R2 presence, short pulses
    hv_pulses(4, 4, 1'b0);
    check("R2 hv_det", hv_det_o, 1);
    check("R10 short pulses no extract", vx_det_o, 0);
    check("R4 hv_pol positive", hv_pol_o, 0);
    v_sync_i = 1'b1; cyc(4);
    check("R9 pure path high", v_sync_o, 1);
    v_sync_i = 1'b0; cyc(PER);
    check("R9 pure path idle", v_sync_o, 0);
    check("R2 v_det", v_det_o, 1);
    cyc(200);
    check("R2 hv_det sticky", hv_det_o, 1);

    // R3 clear at acknowledge only
    wr(1'b1, 1'b0, 1'b0);
    cyc(5);
    check("R3 flags kept before ack", {hv_det_o, v_det_o}, 3);
    ack();
    check("R3 flags cleared at ack", {hv_det_o, v_det_o, vx_det_o}, 0);
    hv_pulses(1, 4, 1'b0);
    check("R3 rearmed hv", hv_det_o, 1);
    check("R3 v still clear", v_det_o, 0);
    wr(1'b0, 1'b0, 1'b0);
    ack();
    check("R3 ack without clear bit", hv_det_o, 1);

    // R4 random polarity on both inputs
    for (int i = 0; i < 8; i++) begin
      automatic logic neg = 1'($urandom % 2);
      automatic int w = 3 + int'($urandom % 18);
      hv_pulses(4, w, neg);
      check("R4 hv_pol", hv_pol_o, exp_pol(neg ? PER - w : w, neg ? w : PER - w));
      check("R4 hv_sync idle low", hv_sync_o, 0);
      v_pulses(4, w, ~neg);
      check("R4 v_pol", v_pol_o, exp_pol(neg ? w : PER - w, neg ? PER - w : w));
      check("R4 v_sync idle low", v_sync_o, 0);
    end
    hv_pulses(3, 4, 1'b0);
    v_pulses(3, 4, 1'b0);
    check("R4 hv_pol restored", hv_pol_o, 0);

    // R5 host select
    wr(1'b0, 1'b0, 1'b1);
    check("R5 vsel written", vsel_o, 1);
    cyc(50);
    check("R5 vsel held", vsel_o, 1);

    // R10 extractor with hysteresis, seen through v_sync_o (R9)
    wr(1'b1, 1'b0, 1'b1);
    ack();
    hv_pulses(4, 4, 1'b0);
    check("R10 no extract from line pulses", {vx_det_o, v_sync_o}, 0);
    hv_sync_i = 1'b1; cyc(56);
    check("R10 extracted high", v_sync_o, 1);
    check("R2 vx_det", vx_det_o, 1);
    cyc(4);
    hv_sync_i = 1'b0; cyc(20);
    check("R10 hysteresis holds", v_sync_o, 1);
    cyc(40);
    check("R10 extracted released", v_sync_o, 0);
    check("R4 long pulse keeps pol", hv_pol_o, 0);

    // automatic mode
    wr(1'b0, 1'b0, 1'b0);
    wr(1'b1, 1'b0, 1'b0);
    ack();
    wr(1'b0, 1'b1, 1'b1);
    cyc(3);
    check("R6 auto set", auto_o, 1);
    check("R6 R8 vsel ignored and held", vsel_o, 0);
    long_pulse();
    check("R8 only extracted", vsel_o, 1);
    v_pulses(3, 4, 1'b0);
    check("R7 both keep extracted", vsel_o, 1);
    wr(1'b1, 1'b1, 1'b0);
    ack();
    cyc(3);
    check("R8 none holds", vsel_o, 1);
    v_pulses(3, 4, 1'b0);
    check("R8 only pure", vsel_o, 0);
    long_pulse();
    check("R7 both keep pure", {vx_det_o, vsel_o}, 2);
    v_sync_i = 1'b1; cyc(4);
    check("R9 pure path in auto", v_sync_o, 1);
    v_sync_i = 1'b0; cyc(4);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule